// File: doc/BRIEF.md
# Column-Addressed Pixel Line Buffer

This block stores a small two-dimensional array of pixels, by default three rows of five 8-bit values. It serves as the line store in front of a windowed image filter. Each command names one column. Shifts and inserts change only that column, so a new pixel can be pushed into the buffer one column at a time while a neighbouring column is still being read.

A command is an opcode with a valid strobe, a column index, a row index and a data byte. The block applies at most one command per clock edge. The opcode is one-hot, and any other opcode pattern is ignored. The block provides two shifts (toward the bottom row and toward the top row), two inserts (into the top row or the bottom row) and a read. A read reports the addressed pixel on a registered output one clock later. Indices that fall outside the array leave the contents unchanged, and a read at such an index returns zero.

Top module: `pixcol_linebuf`

## Requirements
- R1: While reset is asserted and after it is released, every cell holds zero and `rd_valid` is low until an accepted read.
- R2: Shift-down (opcode bit 0, `5'b00001`) on column c copies row r-1 into row r for every r from 1 to ROWS-1 in column c. The old bottom value is lost and row 0 keeps its value.
- R3: Shift-up (opcode bit 1, `5'b00010`) on column c copies row r+1 into row r for every r from 0 to ROWS-2 in column c. The old top value is lost and the bottom row keeps its value.
- R4: Insert-top (opcode bit 2, `5'b00100`) writes `cmd_data` into row 0 of column c and leaves the other rows untouched.
- R5: Insert-bottom (opcode bit 3, `5'b01000`) writes `cmd_data` into row ROWS-1 of column c and leaves the other rows untouched.
- R6: An accepted command never changes any column other than the one it addresses.
- R7: Read (opcode bit 4, `5'b10000`) raises `rd_valid` on the next clock and presents the pixel at (`cmd_row`, `cmd_col`), taken from the contents before that edge.
- R8: A column index of COLS or more changes nothing. A read with a row index of ROWS or more, or a column index of COLS or more, returns zero with `rd_valid` high.
- R9: A command is accepted only when `cmd_valid` is high and exactly one opcode bit is set. Otherwise the array is unchanged and `rd_valid` stays low.
- R10: Load the rows as 1..5, 6..10 and 11..15, then apply shift-down and insert-top of 100 on column 2. Column 2 then reads 100, 3, 8 from the top down, and cell (1,3) reads 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 5 | One-hot opcode: down, up, insert-top, insert-bottom, read (bit 0 to 4) |
| cmd_row | input | ROW_W (2) | Row index for reads |
| cmd_col | input | COL_W (3) | Column index for every command |
| cmd_data | input | PIX_W (8) | Pixel for inserts |
| rd_valid | output | 1 | Read result present |
| rd_data | output | PIX_W (8) | Pixel returned by the previous read |

## Verification
A change to the array takes effect at the edge that accepts the command. A read result appears one edge after the read is accepted. The bench drives each command at a falling edge, advances its behavioural model at the same point, and samples `rd_valid` and `rd_data` at the next falling edge, so every read is compared exactly one clock after it was issued. Because array contents are only visible through reads, the bench reads back whole columns after shifts, inserts, out-of-range commands and rejected opcodes. This shows that untouched cells kept their values.

// File: rtl/pixcol_linebuf.sv
module pixcol_linebuf #(
  parameter int ROWS  = 3,
  parameter int COLS  = 5,
  parameter int PIX_W = 8,
  parameter int ROW_W = $clog2(ROWS + 1),
  parameter int COL_W = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [4:0]       cmd_op,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [PIX_W-1:0] cmd_data,
  output logic             rd_valid,
  output logic [PIX_W-1:0] rd_data
);

  localparam logic [4:0] OP_DOWN = 5'b00001;
  localparam logic [4:0] OP_UP   = 5'b00010;
  localparam logic [4:0] OP_TOP  = 5'b00100;
  localparam logic [4:0] OP_BOT  = 5'b01000;
  localparam logic [4:0] OP_RD   = 5'b10000;

  logic [PIX_W-1:0] mem    [ROWS][COLS];
  logic [PIX_W-1:0] mem_nx [ROWS][COLS];
  logic [PIX_W-1:0] rd_pick;
  logic             acc;
  logic             rd_valid_q;
  logic [PIX_W-1:0] rd_data_q;

  assign acc = cmd_valid && (cmd_op != 5'd0) && ((cmd_op & (cmd_op - 5'd1)) == 5'd0);

  always_comb begin
    mem_nx = mem;
    if (acc) begin
      for (int c = 0; c < COLS; c++) begin
        if (cmd_col == COL_W'(c)) begin
          for (int r = 0; r < ROWS; r++) begin
            unique case (cmd_op)
              OP_DOWN: mem_nx[r][c] = mem[(r > 0) ? r - 1 : 0][c];
              OP_UP:   mem_nx[r][c] = mem[(r < ROWS - 1) ? r + 1 : r][c];
              OP_TOP:  if (r == 0)        mem_nx[r][c] = cmd_data;
              OP_BOT:  if (r == ROWS - 1) mem_nx[r][c] = cmd_data;
              default: ;
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    rd_pick = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (cmd_row == ROW_W'(r) && cmd_col == COL_W'(c))
          rd_pick = mem[r][c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem        <= '{default: '0};
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      mem        <= mem_nx;
      rd_valid_q <= acc && (cmd_op == OP_RD);
      rd_data_q  <= (acc && cmd_op == OP_RD) ? rd_pick : '0;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  for (genvar c = 0; c < COLS; c++) begin : g_chk_col
    for (genvar r = 1; r < ROWS; r++) begin : g_chk_dn
      assert_shift_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_DOWN && cmd_col == COL_W'(c)) |=> mem[r][c] == $past(mem[r-1][c]));
    end
    for (genvar r = 0; r < ROWS - 1; r++) begin : g_chk_up
      assert_shift_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_UP && cmd_col == COL_W'(c)) |=> mem[r][c] == $past(mem[r+1][c]));
    end
    assert_ins_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_TOP && cmd_col == COL_W'(c)) |=> mem[0][c] == $past(cmd_data));
    assert_ins_bot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_BOT && cmd_col == COL_W'(c)) |=> mem[ROWS-1][c] == $past(cmd_data));
    for (genvar r = 0; r < ROWS; r++) begin : g_chk_keep
      assert_other_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_col != COL_W'(c)) |=> $stable(mem[r][c]));
      assert_bad_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || $countones(cmd_op) != 1) |=> $stable(mem[r][c]));
    end
  end

  assert_read_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid) && $past(cmd_op) == OP_RD);
  assert_oob_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RD && (cmd_row >= ROW_W'(ROWS) || cmd_col >= COL_W'(COLS)))
    |=> rd_valid && rd_data == '0);
  assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && $countones(cmd_op) != 1) |=> !rd_valid);

endmodule

// File: tb/sim_pixcol_linebuf.sv
`timescale 1ns/1ps
module sim_pixcol_linebuf;
  localparam int ROWS = 3, COLS = 5, PIX_W = 8, ROW_W = 2, COL_W = 3;
  localparam logic [4:0] DN = 5'b00001, UP = 5'b00010, TOP = 5'b00100, BOT = 5'b01000, RD = 5'b10000;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [4:0] cmd_op = 0;
  logic [ROW_W-1:0] cmd_row = 0;
  logic [COL_W-1:0] cmd_col = 0;
  logic [PIX_W-1:0] cmd_data = 0;
  logic rd_valid;
  logic [PIX_W-1:0] rd_data;

  int checks = 0, errors = 0;
  int mdl [ROWS][COLS];
  bit finished = 0;

  always #4 clk = ~clk;

  pixcol_linebuf u0 (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [4:0] v);
    int n = 0;
    for (int i = 0; i < 5; i++) n += v[i];
    return n;
  endfunction

  // Drive at a falling edge, update model, sample at the next falling edge.
  task automatic step(input string req, input logic v, input logic [4:0] op,
                      input int row, input int col, input int data);
    bit ok, ev;
    int ed;
    cmd_valid = v; cmd_op = op; cmd_row = ROW_W'(row); cmd_col = COL_W'(col); cmd_data = PIX_W'(data);
    ok = v && ones(op) == 1;
    ev = ok && op == RD;
    ed = 0;
    if (ev && row < ROWS && col < COLS) ed = mdl[row][col];
    if (ok && col < COLS) begin
      case (op)
        DN:  for (int r = ROWS - 1; r > 0; r--) mdl[r][col] = mdl[r-1][col];
        UP:  for (int r = 0; r < ROWS - 1; r++) mdl[r][col] = mdl[r+1][col];
        TOP: mdl[0][col] = data & 8'hFF;
        BOT: mdl[ROWS-1][col] = data & 8'hFF;
        default: ;
      endcase
    end
    @(negedge clk);
    check({req, " rd_valid"}, rd_valid, ev);
    check({req, " rd_data"}, rd_data, ed);
  endtask

  task automatic read_all(input string req);
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) step(req, 1, RD, r, c, 0);
  endtask

  task automatic read_lit(input string req, input int row, input int col, input int exp);
    step(req, 1, RD, row, col, 0);
    check({req, " literal"}, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) mdl[r][c] = 0;
    cmd_valid = 1; cmd_op = TOP; cmd_data = 8'h55;
    repeat (3) @(negedge clk);
    check("R1 reset rd_valid", rd_valid, 0);
    cmd_valid = 0;
    rst_n = 1;
    read_all("R1 reset contents");

    // R10 load pattern via insert-top and shift-down
    for (int c = 0; c < COLS; c++) begin
      step("R4 load", 1, TOP, 0, c, 11 + c);
      step("R2 load", 1, DN, 0, c, 0);
      step("R4 load", 1, TOP, 0, c, 6 + c);
      step("R2 load", 1, DN, 0, c, 0);
      step("R4 load", 1, TOP, 0, c, 1 + c);
    end
    read_all("R2 R4 loaded");
    step("R2 example", 1, DN, 0, 2, 0);
    step("R4 example", 1, TOP, 0, 2, 100);
    read_lit("R10", 0, 2, 100);
    read_lit("R10", 1, 2, 3);
    read_lit("R10", 2, 2, 8);
    read_lit("R10", 1, 3, 9);
    read_all("R6 neighbours");

    step("R3 up", 1, UP, 0, 4, 0);
    read_lit("R3", 0, 4, 10);
    read_lit("R3", 1, 4, 15);
    read_lit("R3", 2, 4, 15);
    step("R5 bottom", 1, BOT, 0, 0, 77);
    read_lit("R5", 2, 0, 77);
    read_lit("R5", 1, 0, 6);
    read_all("R6 after up/bottom");

    step("R8 col5 insert", 1, TOP, 0, 5, 200);
    step("R8 col7 shift", 1, DN, 0, 7, 0);
    read_lit("R8 row3", 3, 1, 0);
    read_lit("R8 col5", 0, 5, 0);
    read_lit("R8 col6", 1, 6, 0);
    read_all("R8 unchanged");

    step("R9 no bits", 1, 5'b00000, 0, 1, 9);
    step("R9 two bits", 1, TOP | BOT, 0, 1, 9);
    step("R9 read+top", 1, RD | TOP, 0, 1, 9);
    step("R9 invalid", 0, TOP, 0, 1, 9);
    step("R9 invalid read", 0, RD, 0, 1, 0);
    read_all("R9 unchanged");

    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 9);
      logic [4:0] op = (k < 5) ? (5'b1 << k) : RD;
      step("R7 random", $urandom_range(0, 7) != 0, op,
           $urandom_range(0, 3), $urandom_range(0, 6), $urandom_range(0, 255));
    end
    read_all("R7 final");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule